// File: doc/BRIEF.md
# Dual-Port Processor Mailbox

This block links two processors, called side A and side B, through a pair of word FIFOs and a small sync channel. Each side sees the same four-register window, chosen by a 2-bit select: a sync register, a control/status register, a send port and a receive port. A word that one side writes to its send port is queued and later read from the other side's receive port. The two directions are independent, so both processors can post and drain in the same cycle.

The sync register carries an 8-bit tag from one side to the other. It is also how a side rings a doorbell interrupt on its partner. The control register reports the fill state of both queues and controls a set of things:

- the FIFO enable;
- the two FIFO interrupt enables;
- a flush of the local send queue;
- a sticky error flag. This flag records a read from an empty queue or a write to a full one.

Register reads are combinational from the current state. A write or a receive pop takes effect at the rising clock edge.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset each control register reads 0x0000_0101 (both queues empty, everything disabled), each sync register reads 0, and all four interrupt outputs are low.
- R2: With the FIFO enable set, words written to select 2 on one side are read in the same order from select 3 on the other side. A read pops the word it returns, and each queue holds 16 words.
- R3: Control bit 0 is 1 when the local send queue is empty and bit 1 is 1 when it holds 16 words. Bits 8 and 9 report the same two conditions for the receive queue.
- R4: Writing a control word with bit 3 set empties the local send queue in that cycle, whatever the FIFO enable is. A pop by the partner in the same cycle does not survive the flush.
- R5: Control bit 14 becomes 1 after an enabled receive read while the receive queue is empty, or an enabled send write while the send queue is full. A control write with bit 14 set clears it. A write to a full queue is dropped.
- R6: While control bit 15 is 0, send writes and receive reads have no effect on either queue, on the error flag or on the remembered word.
- R7: A sync write stores bits 15:8, and the partner reads that value in its sync bits 7:0. Sync bits 15:8 and 30:8 always read 0, and bit 31 reads back as the written interrupt enable.
- R8: A sync write with bit 30 set drives the partner's irq_sync high for exactly the following cycle, provided the partner's sync bit 31 is 1 then. With bit 30 clear, the write raises nothing.
- R9: irq_fifo is high exactly when (send queue empty AND control bit 2) OR (receive queue not empty AND control bit 10).
- R10: A receive read while the queue is empty returns the last word that side popped, or 0 if it has never popped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_sel | input | 2 | Side A register select: 0 sync, 1 control, 2 send, 3 receive |
| a_wr | input | 1 | Side A write strobe |
| a_rd | input | 1 | Side A read strobe (pops on select 3) |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A read data for the selected register |
| a_irq_fifo | output | 1 | Side A FIFO interrupt (level) |
| a_irq_sync | output | 1 | Side A doorbell interrupt from side B |
| b_sel | input | 2 | Side B register select |
| b_wr | input | 1 | Side B write strobe |
| b_rd | input | 1 | Side B read strobe |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B read data |
| b_irq_fifo | output | 1 | Side B FIFO interrupt (level) |
| b_irq_sync | output | 1 | Side B doorbell interrupt from side A |

## Verification
The bench fills a queue to 16 and writes once more. A design with an off-by-one depth would either accept the seventeenth word or report full one word early. It then drains past empty to catch an error flag that never latches, or a read that returns garbage instead of the last popped word. The bench also flushes a queue and disables the FIFOs while traffic is pending. A flush that loses to a concurrent pop, or an enable that fails to gate accesses, shows up as a wrong count in the partner's status. Finally, it checks that the sync tag never reads back on the writing side and that doorbells depend on the partner's enable bit. A design that latched the doorbell instead of pulsing it would hold irq_sync high for more than one cycle.

// File: rtl/ipc_mailbox.sv
`timescale 1ns/1ps
module ipc_mailbox #(
  parameter int W     = 32,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   a_sel,
  input  logic         a_wr,
  input  logic         a_rd,
  input  logic [W-1:0] a_wdata,
  output logic [W-1:0] a_rdata,
  output logic         a_irq_fifo,
  output logic         a_irq_sync,
  input  logic [1:0]   b_sel,
  input  logic         b_wr,
  input  logic         b_rd,
  input  logic [W-1:0] b_wdata,
  output logic [W-1:0] b_rdata,
  output logic         b_irq_fifo,
  output logic         b_irq_sync
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [1:0] SEL_SYNC = 2'd0, SEL_CTL = 2'd1, SEL_TX = 2'd2, SEL_RX = 2'd3;

  logic         wr [2];
  logic         rd [2];
  logic [1:0]   sel[2];
  logic [W-1:0] wd [2];
  logic [W-1:0] rdat[2];

  assign wr[0] = a_wr;    assign wr[1] = b_wr;
  assign rd[0] = a_rd;    assign rd[1] = b_rd;
  assign sel[0] = a_sel;  assign sel[1] = b_sel;
  assign wd[0] = a_wdata; assign wd[1] = b_wdata;

  // queue s is written by side s and drained by side 1-s
  logic [W-1:0]  mem [2][DEPTH];
  logic [AW-1:0] wp  [2];
  logic [AW-1:0] rp  [2];
  logic [CW-1:0] cnt [2];
  logic [7:0]    sval[2];
  logic          sen [2];
  logic          sirq[2];
  logic          rirq[2];
  logic          fen [2];
  logic          err [2];
  logic          db  [2];
  logic [W-1:0]  last[2];

  logic empty[2], full[2], push[2], pop[2], flush[2], bad[2], ctlw[2];

  always_comb begin
    for (int s = 0; s < 2; s++) begin
      empty[s] = (cnt[s] == '0);
      full[s]  = (cnt[s] == CW'(DEPTH));
    end
    for (int s = 0; s < 2; s++) begin
      ctlw[s]  = wr[s] && sel[s] == SEL_CTL;
      flush[s] = ctlw[s] && wd[s][3];
      push[s]  = fen[s] && wr[s] && sel[s] == SEL_TX && !full[s];
      pop[s]   = fen[s] && rd[s] && !wr[s] && sel[s] == SEL_RX && !empty[1-s];
      bad[s]   = fen[s] && ((wr[s] && sel[s] == SEL_TX && full[s]) ||
                            (rd[s] && !wr[s] && sel[s] == SEL_RX && empty[1-s]));
      case (sel[s])
        SEL_SYNC: rdat[s] = {sen[s], {(W-9){1'b0}}, sval[1-s]};
        SEL_CTL:  rdat[s] = {{(W-16){1'b0}}, fen[s], err[s], 3'b000, rirq[s],
                             full[1-s], empty[1-s], 5'b00000, sirq[s], full[s], empty[s]};
        SEL_TX:   rdat[s] = '0;
        default:  rdat[s] = empty[1-s] ? last[s] : mem[1-s][rp[1-s]];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < 2; s++) begin
        wp[s] <= '0; rp[s] <= '0; cnt[s] <= '0;
        sval[s] <= '0; sen[s] <= 1'b0; sirq[s] <= 1'b0; rirq[s] <= 1'b0;
        fen[s] <= 1'b0; err[s] <= 1'b0; db[s] <= 1'b0; last[s] <= '0;
      end
    end else begin
      for (int s = 0; s < 2; s++) begin
        if (push[s]) mem[s][wp[s]] <= wd[s];
        if (flush[s]) begin
          wp[s] <= '0; rp[s] <= '0; cnt[s] <= '0;
        end else begin
          if (push[s])   wp[s] <= wp[s] + 1'b1;
          if (pop[1-s])  rp[s] <= rp[s] + 1'b1;
          cnt[s] <= cnt[s] + CW'(push[s]) - CW'(pop[1-s]);
        end
        if (pop[s]) last[s] <= mem[1-s][rp[1-s]];
        db[s] <= wr[s] && sel[s] == SEL_SYNC && wd[s][30];
        if (wr[s] && sel[s] == SEL_SYNC) begin
          sval[s] <= wd[s][15:8];
          sen[s]  <= wd[s][31];
        end
        if (ctlw[s]) begin
          sirq[s] <= wd[s][2];
          rirq[s] <= wd[s][10];
          fen[s]  <= wd[s][15];
        end
        if (bad[s]) err[s] <= 1'b1;
        else if (ctlw[s] && wd[s][14]) err[s] <= 1'b0;
      end
    end
  end

  assign a_rdata    = rdat[0];
  assign b_rdata    = rdat[1];
  assign a_irq_fifo = (empty[0] && sirq[0]) || (!empty[1] && rirq[0]);
  assign b_irq_fifo = (empty[1] && sirq[1]) || (!empty[0] && rirq[1]);
  assign a_irq_sync = db[1] && sen[0];
  assign b_irq_sync = db[0] && sen[1];

  AST_CNT_LIMIT_A: assert property (@(posedge clk) disable iff (!rst_n) cnt[0] <= CW'(DEPTH)); // R2
  AST_CNT_LIMIT_B: assert property (@(posedge clk) disable iff (!rst_n) cnt[1] <= CW'(DEPTH)); // R2
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (a_wr && a_sel == SEL_CTL && a_wdata[3]) |=> (a_rdata[0] || a_sel != SEL_CTL) && b_rdata[9:8] != 2'b10 ? cnt[0] == '0 : cnt[0] == '0); // R4
  AST_ERR_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (a_rd && !a_wr && a_sel == SEL_RX && fen[0] && empty[1]) |=> err[0]); // R5
  AST_DISABLED_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (a_wr && a_sel == SEL_TX && !fen[0]) |=> cnt[0] <= $past(cnt[0])); // R6
  AST_SYNC_TAG_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
    (a_sel == SEL_SYNC) |-> a_rdata[15:8] == 8'h00); // R7
  AST_DOORBELL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    b_irq_sync |-> $past(a_wr && a_sel == SEL_SYNC && a_wdata[30])); // R8
endmodule

// File: tb/ipc_mailbox_tb.sv
`timescale 1ns/1ps
module ipc_mailbox_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        i_wr[2], i_rd[2];
  logic [1:0]  i_sel[2];
  logic [31:0] i_wd[2];
  logic [31:0] a_rdata, b_rdata;
  logic a_irq_fifo, a_irq_sync, b_irq_fifo, b_irq_sync;

  ipc_mailbox u_dut (
    .clk(clk), .rst_n(rst_n),
    .a_sel(i_sel[0]), .a_wr(i_wr[0]), .a_rd(i_rd[0]), .a_wdata(i_wd[0]),
    .a_rdata(a_rdata), .a_irq_fifo(a_irq_fifo), .a_irq_sync(a_irq_sync),
    .b_sel(i_sel[1]), .b_wr(i_wr[1]), .b_rd(i_rd[1]), .b_wdata(i_wd[1]),
    .b_rdata(b_rdata), .b_irq_fifo(b_irq_fifo), .b_irq_sync(b_irq_sync)
  );

  int vectors = 0, miscompares = 0;
  string phase = "R1";

  logic [31:0] q0[$], q1[$];
  logic [7:0]  m_sval[2];
  logic        m_sen[2], m_sirq[2], m_rirq[2], m_en[2], m_err[2], m_db[2];
  logic [31:0] m_last[2];

  function automatic int qsz(int s);
    return (s == 0) ? q0.size() : q1.size();
  endfunction
  function automatic logic [31:0] qhd(int s);
    return (s == 0) ? q0[0] : q1[0];
  endfunction

  function automatic logic [31:0] exp_rd(int s);
    int o = 1 - s;
    case (i_sel[s])
      2'd0: return {m_sen[s], 23'b0, m_sval[o]};
      2'd1: return {16'b0, m_en[s], m_err[s], 3'b0, m_rirq[s], qsz(o) == 16, qsz(o) == 0,
                    5'b0, m_sirq[s], qsz(s) == 16, qsz(s) == 0};
      2'd2: return 32'h0;
      default: return (qsz(o) == 0) ? m_last[s] : qhd(o);
    endcase
  endfunction

  function automatic string tag_of(logic [1:0] sl);
    case (sl)
      2'd0: return "R7";
      2'd1: return "R3";
      2'd2: return "R7";
      default: return "R2/R10";
    endcase
  endfunction

  task automatic cmp(string what, string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s (%s, phase %s) act=%h exp=%h t=%0t", tag, what, phase, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    cmp("a_rdata", tag_of(i_sel[0]), a_rdata, exp_rd(0));
    cmp("b_rdata", tag_of(i_sel[1]), b_rdata, exp_rd(1));
    cmp("a_irq_fifo", "R9", {31'b0, a_irq_fifo},
        {31'b0, (qsz(0) == 0 && m_sirq[0]) || (qsz(1) != 0 && m_rirq[0])});
    cmp("b_irq_fifo", "R9", {31'b0, b_irq_fifo},
        {31'b0, (qsz(1) == 0 && m_sirq[1]) || (qsz(0) != 0 && m_rirq[1])});
    cmp("a_irq_sync", "R8", {31'b0, a_irq_sync}, {31'b0, m_db[1] && m_sen[0]});
    cmp("b_irq_sync", "R8", {31'b0, b_irq_sync}, {31'b0, m_db[0] && m_sen[1]});
  endtask

  task automatic model_step();
    logic push[2], pop[2], fl[2], bad[2], cw[2];
    logic [31:0] pv[2];
    int sz[2];
    sz[0] = qsz(0); sz[1] = qsz(1);
    for (int s = 0; s < 2; s++) begin
      cw[s]   = i_wr[s] && i_sel[s] == 2'd1;
      fl[s]   = cw[s] && i_wd[s][3];
      push[s] = m_en[s] && i_wr[s] && i_sel[s] == 2'd2 && sz[s] < 16;
      pop[s]  = m_en[s] && i_rd[s] && !i_wr[s] && i_sel[s] == 2'd3 && sz[1-s] > 0;
      bad[s]  = m_en[s] && ((i_wr[s] && i_sel[s] == 2'd2 && sz[s] == 16) ||
                            (i_rd[s] && !i_wr[s] && i_sel[s] == 2'd3 && sz[1-s] == 0));
      pv[s]   = pop[s] ? qhd(1-s) : 32'h0;
    end
    for (int s = 0; s < 2; s++) begin
      if (pop[s]) m_last[s] = pv[s];
      m_db[s] = i_wr[s] && i_sel[s] == 2'd0 && i_wd[s][30];
      if (i_wr[s] && i_sel[s] == 2'd0) begin
        m_sval[s] = i_wd[s][15:8];
        m_sen[s]  = i_wd[s][31];
      end
      if (cw[s]) begin
        m_sirq[s] = i_wd[s][2];
        m_rirq[s] = i_wd[s][10];
        m_en[s]   = i_wd[s][15];
      end
      if (bad[s]) m_err[s] = 1'b1;
      else if (cw[s] && i_wd[s][14]) m_err[s] = 1'b0;
    end
    if (fl[0]) q0.delete();
    else begin
      if (pop[1]) void'(q0.pop_front());
      if (push[0]) q0.push_back(i_wd[0]);
    end
    if (fl[1]) q1.delete();
    else begin
      if (pop[0]) void'(q1.pop_front());
      if (push[1]) q1.push_back(i_wd[1]);
    end
  endtask

  task automatic cyc(input logic [1:0] as, input logic aw, input logic ar, input logic [31:0] ad,
                     input logic [1:0] bs, input logic bw, input logic br, input logic [31:0] bd);
    i_sel[0] = as; i_wr[0] = aw; i_rd[0] = ar; i_wd[0] = ad;
    i_sel[1] = bs; i_wr[1] = bw; i_rd[1] = br; i_wd[1] = bd;
    #2;
    compare_all();
    @(posedge clk);
    #1;
    model_step();
    @(negedge clk);
  endtask

  task automatic a_wr(input logic [1:0] s, input logic [31:0] d); cyc(s, 1, 0, d, 2'd1, 0, 0, 0); endtask
  task automatic b_wr(input logic [1:0] s, input logic [31:0] d); cyc(2'd1, 0, 0, 0, s, 1, 0, d); endtask
  task automatic a_rd(input logic [1:0] s); cyc(s, 0, 1, 0, 2'd1, 0, 0, 0); endtask
  task automatic b_rd(input logic [1:0] s); cyc(2'd1, 0, 0, 0, s, 0, 1, 0); endtask
  task automatic idle(input logic [1:0] as, input logic [1:0] bs); cyc(as, 0, 0, 0, bs, 0, 0, 0); endtask

  initial begin
    #4_000_000;
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    for (int s = 0; s < 2; s++) begin
      i_wr[s] = 0; i_rd[s] = 0; i_sel[s] = 2'd1; i_wd[s] = 0;
      m_sval[s] = 0; m_sen[s] = 0; m_sirq[s] = 0; m_rirq[s] = 0;
      m_en[s] = 0; m_err[s] = 0; m_db[s] = 0; m_last[s] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state of control and sync
    idle(2'd1, 2'd1);
    idle(2'd0, 2'd0);
    idle(2'd3, 2'd3);
    // R6: traffic while disabled is ignored
    phase = "R6";
    a_wr(2'd2, 32'hDEAD_0001);
    b_rd(2'd3);
    idle(2'd1, 2'd1);
    // R2: enable both, ordered transfer A->B and B->A
    phase = "R2";
    a_wr(2'd1, 32'h0000_8000);
    b_wr(2'd1, 32'h0000_8000);
    for (int i = 0; i < 5; i++) a_wr(2'd2, 32'h1000_0000 + i);
    for (int i = 0; i < 5; i++) b_rd(2'd3);
    cyc(2'd2, 1, 0, 32'hAAAA_0001, 2'd2, 1, 0, 32'hBBBB_0001);
    cyc(2'd3, 0, 1, 0, 2'd3, 0, 1, 0);
    // R3/R5: fill B->A to 16, overflow write
    phase = "R5";
    for (int i = 0; i < 17; i++) b_wr(2'd2, 32'h2000_0000 + i);
    idle(2'd1, 2'd1);
    b_wr(2'd1, 32'h0000_C000);
    idle(2'd1, 2'd1);
    // drain with simultaneous refill, then past empty (R10)
    phase = "R10";
    cyc(2'd3, 0, 1, 0, 2'd2, 1, 0, 32'h3000_0000);
    for (int i = 0; i < 17; i++) a_rd(2'd3);
    a_rd(2'd3);
    idle(2'd1, 2'd3);
    a_wr(2'd1, 32'h0000_C000);
    // R4: flush with concurrent pop
    phase = "R4";
    for (int i = 0; i < 3; i++) a_wr(2'd2, 32'h4000_0000 + i);
    cyc(2'd1, 1, 0, 32'h0000_8008, 2'd3, 0, 1, 0);
    b_rd(2'd3);
    idle(2'd1, 2'd1);
    a_wr(2'd1, 32'h0000_0008);
    // R6: disable with pending word
    phase = "R6";
    a_wr(2'd1, 32'h0000_8000);
    a_wr(2'd2, 32'h5000_0001);
    b_wr(2'd1, 32'h0000_0000);
    b_rd(2'd3);
    a_wr(2'd1, 32'h0000_0000);
    a_wr(2'd2, 32'h5000_0002);
    idle(2'd1, 2'd1);
    b_wr(2'd1, 32'h0000_8000);
    b_rd(2'd3);
    b_rd(2'd3);
    // R7: sync tag
    phase = "R7";
    a_wr(2'd0, 32'h0000_5A00);
    idle(2'd0, 2'd0);
    b_wr(2'd0, 32'h0000_C300);
    idle(2'd0, 2'd0);
    // R8: doorbells
    phase = "R8";
    a_wr(2'd0, 32'h4000_0100);
    idle(2'd0, 2'd0);
    b_wr(2'd0, 32'h8000_0000);
    a_wr(2'd0, 32'h4000_0200);
    idle(2'd0, 2'd0);
    idle(2'd0, 2'd0);
    a_wr(2'd0, 32'h0000_0300);
    idle(2'd0, 2'd0);
    a_wr(2'd0, 32'h8000_0000);
    cyc(2'd0, 1, 0, 32'hC000_0000, 2'd0, 1, 0, 32'hC000_1100);
    idle(2'd0, 2'd0);
    // R9: fifo interrupts
    phase = "R9";
    a_wr(2'd1, 32'h0000_8004);
    a_wr(2'd2, 32'h6000_0001);
    b_wr(2'd1, 32'h0000_8400);
    idle(2'd1, 2'd1);
    b_rd(2'd3);
    idle(2'd1, 2'd1);
    b_wr(2'd1, 32'h0000_8404);
    idle(2'd1, 2'd1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule